// File: doc/BRIEF.md
# Modular Signed-Digit Multiplier Tree

This block multiplies two residues held as radix-4 signed-digit numbers and returns their product modulo m, where m is one of 4^P, 4^P−1 or 4^P+1 for a digit count P chosen at build time. It is meant as one residue channel of a residue-number datapath. Operands arrive already in residue form, and the result leaves in residue form, so there is no binary conversion at either edge.

Internally, one partial product is formed per multiplier digit. Each digit product is split into a low digit and a transfer digit, so every partial-product digit stays within ±3. The weight 4^i of the multiplier digit is applied as a cyclic digit shift. Digits that cross the top position wrap back unchanged when m = 4^P−1, wrap back negated when m = 4^P+1, and are discarded when m = 4^P. A binary tree of carry-free modular adders sums the partial products. It has ⌈log2 P⌉ levels, and an odd node at a level passes through unchanged. A final normalising stage rewrites the sum into the digit set {−2…2} and folds every overflow back according to the modulus. The result is either combinational or held in one output register.

Top module: `sdmod_mult`

## Requirements
- R1: Each digit is a 3-bit two's-complement field, and digit j sits at bits [3j+2:3j] with weight 4^j. Input digits are restricted to {−2…2}, and every output digit lies in {−2…2}.
- R2: The integer value of the output, taken modulo m, equals the product of the two input values modulo m. The value of m is 4^P when MOD_KIND=0, 4^P−1 when MOD_KIND=1 and 4^P+1 when MOD_KIND=2.
- R3: Every partial-product digit stays within {−3…3}, including when all operand digits are 2 so that each digit product reaches 4.
- R4: Every digit of the adder tree's sum stays within {−3…3}, including for operands whose digits are all at opposite extremes.
- R5: With OUT_REG=0 the output follows the inputs in the same cycle. With OUT_REG=1 the output changes only at a rising clock edge, holding the product of the inputs present at that edge. While rst_n is low the output register holds all zero digits.
- R6: If either operand is all zero digits, the output is all zero digits.
- R7: The final normalisation never leaves an unabsorbed overflow, even when a wrapped carry runs through every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_i | input | 3*DIGITS | Multiplicand, signed digits |
| y_i | input | 3*DIGITS | Multiplier, signed digits |
| z_o | output | 3*DIGITS | Product modulo m, signed digits |

## Verification
A combinational instance presents its product in the same cycle the operands settle. A registered instance presents its product from the rising edge that samples the operands, and keeps the previous product until that edge. The bench drives operands on the falling edge and reads every result 2 ns after the next rising edge. For each registered instance, it also reads the output 2 ns after the falling edge, where the previous product must still be present. Small digit counts are covered exhaustively, larger ones by seeded random operands together with directed extreme patterns.

// File: rtl/sdmod_mult.sv
module sdmod_mult #(
  parameter int DIGITS   = 4,
  parameter int MOD_KIND = 1,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*DIGITS-1:0]   x_i,
  input  logic [3*DIGITS-1:0]   y_i,
  output logic [3*DIGITS-1:0]   z_o
);
  localparam int W   = 3 * DIGITS;
  localparam int LEV = $clog2(DIGITS);

  typedef logic [W-1:0] vec_t;

  function automatic int dg(vec_t v, int j);
    return int'($signed(v[3*j +: 3]));
  endfunction

  function automatic logic [2:0] enc(int d);
    return 3'(d);
  endfunction

  // weight of 4^DIGITS folded back onto digit 0
  function automatic int fold(int c);
    if (MOD_KIND == 1) return c;
    if (MOD_KIND == 2) return -c;
    return 0;
  endfunction

  function automatic bit in_range(vec_t v, int lim);
    for (int j = 0; j < DIGITS; j++)
      if (dg(v, j) > lim || dg(v, j) < -lim) return 1'b0;
    return 1'b1;
  endfunction

  function automatic vec_t part(vec_t x, int yd, int sh);
    int   q;
    int   cin;
    int   t [DIGITS];
    int   l [DIGITS];
    vec_t d;
    vec_t r;
    for (int j = 0; j < DIGITS; j++) begin
      q    = dg(x, j) * yd;
      t[j] = (q >= 3) ? 1 : ((q <= -3) ? -1 : 0);
      l[j] = q - 4 * t[j];
    end
    cin = fold(t[DIGITS-1]);
    for (int j = 0; j < DIGITS; j++) begin
      d[3*j +: 3] = enc(l[j] + cin);
      cin = t[j];
    end
    for (int k = 0; k < DIGITS; k++) begin
      if (k >= sh) r[3*k +: 3] = d[3*(k-sh) +: 3];
      else         r[3*k +: 3] = enc(fold(dg(d, DIGITS - sh + k)));
    end
    return r;
  endfunction

  function automatic vec_t madd(vec_t a, vec_t b);
    int   s;
    int   cin;
    int   t [DIGITS];
    int   w [DIGITS];
    vec_t r;
    for (int j = 0; j < DIGITS; j++) begin
      s    = dg(a, j) + dg(b, j);
      t[j] = (s >= 2) ? 1 : ((s <= -2) ? -1 : 0);
      w[j] = s - 4 * t[j];
    end
    cin = fold(t[DIGITS-1]);
    for (int j = 0; j < DIGITS; j++) begin
      r[3*j +: 3] = enc(w[j] + cin);
      cin = t[j];
    end
    return r;
  endfunction

  function automatic vec_t ripple(vec_t v, int cin, output int cout);
    int   u;
    int   c;
    vec_t r;
    c = cin;
    for (int j = 0; j < DIGITS; j++) begin
      u = dg(v, j) + c;
      if (u > 2) begin
        u = u - 4;
        c = 1;
      end else if (u < -2) begin
        u = u + 4;
        c = -1;
      end else begin
        c = 0;
      end
      r[3*j +: 3] = enc(u);
    end
    cout = c;
    return r;
  endfunction

  vec_t node [0:LEV][0:DIGITS-1];
  vec_t root;
  vec_t e1, e2, res;
  int   c1, c2, c3;

  for (genvar i = 0; i < DIGITS; i++) begin : g_pp
    assign node[0][i] = part(x_i, dg(y_i, i), i);

    p_pp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_range(node[0][i], 3))
      else $error("partial product %0d left {-3..3}", i);
  end

  for (genvar l = 1; l <= LEV; l++) begin : g_lvl
    localparam int NP = (DIGITS + (1 << (l-1)) - 1) >> (l-1);
    for (genvar k = 0; k < DIGITS; k++) begin : g_node
      if (2*k + 1 < NP) begin : g_add
        assign node[l][k] = madd(node[l-1][2*k], node[l-1][2*k+1]);
      end else if (2*k < NP) begin : g_pass
        assign node[l][k] = node[l-1][2*k];
      end else begin : g_idle
        assign node[l][k] = '0;
      end
    end
  end

  assign root = node[LEV][0];

  always_comb begin
    e1  = ripple(root, 0, c1);
    e2  = ripple(e1, fold(c1), c2);
    res = ripple(e2, fold(c2), c3);
  end

  if (OUT_REG) begin : g_reg
    vec_t z_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_q <= '0;
      else        z_q <= res;
    end
    assign z_o = z_q;

    p_reg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $stable(x_i) && $stable(y_i) |=> $stable(z_o))
      else $error("registered product moved with steady operands");
  end else begin : g_comb
    assign z_o = res;
  end

  p_in_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_range(x_i, 2) && in_range(y_i, 2))
    else $error("operand digit outside {-2..2}");

  p_out_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_range(z_o, 2))
    else $error("output digit outside {-2..2}");

  p_root_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_range(root, 3))
    else $error("tree sum digit outside {-3..3}");

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c3 == 0)
    else $error("normalisation left a carry");

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (x_i == '0 || y_i == '0) |-> res == '0)
    else $error("zero operand gave nonzero product");

endmodule

// File: tb/sim_sdmod_mult.sv
module sim_sdmod_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [11:0] x0 = '0, y0 = '0, z0;
  logic [5:0]  x1 = '0, y1 = '0, z1;
  logic [5:0]  x2 = '0, y2 = '0, z2;
  logic [8:0]  x3 = '0, y3 = '0, z3;
  logic [14:0] x4 = '0, y4 = '0, z4;

  longint prev0 = 0, prev4 = 0;

  sdmod_mult #(.DIGITS(4), .MOD_KIND(1), .OUT_REG(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .x_i(x0), .y_i(y0), .z_o(z0));
  sdmod_mult #(.DIGITS(2), .MOD_KIND(2), .OUT_REG(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .x_i(x1), .y_i(y1), .z_o(z1));
  sdmod_mult #(.DIGITS(2), .MOD_KIND(0), .OUT_REG(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .x_i(x2), .y_i(y2), .z_o(z2));
  sdmod_mult #(.DIGITS(3), .MOD_KIND(1), .OUT_REG(1'b0)) u3 (.clk(clk), .rst_n(rst_n), .x_i(x3), .y_i(y3), .z_o(z3));
  sdmod_mult #(.DIGITS(5), .MOD_KIND(2), .OUT_REG(1'b1)) u4 (.clk(clk), .rst_n(rst_n), .x_i(x4), .y_i(y4), .z_o(z4));

  function automatic longint sval(logic [23:0] v, int n);
    longint s = 0;
    for (int j = n - 1; j >= 0; j--) s = s * 4 + longint'($signed(v[3*j +: 3]));
    return s;
  endfunction

  function automatic longint modm(longint v, longint m);
    longint r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  function automatic bit digs_ok(logic [23:0] v, int n);
    for (int j = 0; j < n; j++)
      if ($signed(v[3*j +: 3]) > 2 || $signed(v[3*j +: 3]) < -2) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [23:0] from_code(int code, int n);
    logic [23:0] v = '0;
    int c = code;
    for (int j = 0; j < n; j++) begin
      v[3*j +: 3] = 3'((c % 5) - 2);
      c = c / 5;
    end
    return v;
  endfunction

  function automatic logic [23:0] rnd(int n);
    logic [23:0] v = '0;
    for (int j = 0; j < n; j++) v[3*j +: 3] = 3'(int'($urandom_range(0, 4)) - 2);
    return v;
  endfunction

  function automatic logic [23:0] fill(int d, int n);
    logic [23:0] v = '0;
    for (int j = 0; j < n; j++) v[3*j +: 3] = 3'(d);
    return v;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic judge(string req, string name, logic [23:0] z, logic [23:0] a,
                       logic [23:0] b, int n, longint m);
    check("R1", {name, " digit set"}, longint'(digs_ok(z, n)), 1);
    check(req, {name, " product"}, modm(sval(z, n), m), modm(sval(a, n) * sval(b, n), m));
  endtask

  // call right after operands change at a falling edge
  task automatic do_step(string req);
    #2;
    check("R5", "u0 holds until edge", modm(sval({12'b0, z0}, 4), 255), prev0);
    check("R5", "u4 holds until edge", modm(sval({9'b0, z4}, 5), 1025), prev4);
    @(posedge clk);
    #2;
    judge(req, "u0", {12'b0, z0}, {12'b0, x0}, {12'b0, y0}, 4, 255);
    judge(req, "u1", {18'b0, z1}, {18'b0, x1}, {18'b0, y1}, 2, 17);
    judge(req, "u2", {18'b0, z2}, {18'b0, x2}, {18'b0, y2}, 2, 16);
    judge(req, "u3", {15'b0, z3}, {15'b0, x3}, {15'b0, y3}, 3, 63);
    judge(req, "u4", {9'b0, z4}, {9'b0, x4}, {9'b0, y4}, 5, 1025);
    prev0 = modm(sval({12'b0, x0}, 4) * sval({12'b0, y0}, 4), 255);
    prev4 = modm(sval({9'b0, x4}, 5) * sval({9'b0, y4}, 5), 1025);
  endtask

  task automatic drive_fill(int da, int db);
    x0 = fill(da, 4)[11:0]; y0 = fill(db, 4)[11:0];
    x1 = fill(da, 2)[5:0];  y1 = fill(db, 2)[5:0];
    x2 = fill(da, 2)[5:0];  y2 = fill(db, 2)[5:0];
    x3 = fill(da, 3)[8:0];  y3 = fill(db, 3)[8:0];
    x4 = fill(da, 5)[14:0]; y4 = fill(db, 5)[14:0];
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    x0 = fill(2, 4)[11:0];
    y0 = fill(-2, 4)[11:0];
    x4 = fill(2, 5)[14:0];
    y4 = fill(2, 5)[14:0];
    repeat (3) @(posedge clk);
    #2;
    // R5: register stays at zero digits during reset despite live operands
    check("R5", "u0 reset state", longint'(z0), 0);
    check("R5", "u4 reset state", longint'(z4), 0);

    @(negedge clk);
    rst_n = 1'b1;
    x0 = '0; x1 = '0; x2 = '0; x3 = '0; x4 = '0;
    y0 = rnd(4)[11:0]; y1 = rnd(2)[5:0]; y2 = rnd(2)[5:0]; y3 = rnd(3)[8:0]; y4 = rnd(5)[14:0];
    do_step("R6");
    check("R6", "u3 zero multiplicand digits", longint'(z3), 0);

    @(negedge clk);
    x0 = rnd(4)[11:0]; x1 = rnd(2)[5:0]; x2 = rnd(2)[5:0]; x3 = rnd(3)[8:0]; x4 = rnd(5)[14:0];
    y0 = '0; y1 = '0; y2 = '0; y3 = '0; y4 = '0;
    do_step("R6");
    check("R6", "u4 zero multiplier digits", longint'(z4), 0);
    check("R6", "u1 zero multiplier digits", longint'(z1), 0);

    @(negedge clk); drive_fill(2, 2);   do_step("R3");
    @(negedge clk); drive_fill(-2, 2);  do_step("R4");
    @(negedge clk); drive_fill(2, -2);  do_step("R4");
    @(negedge clk); drive_fill(-2, -2); do_step("R7");
    @(negedge clk); drive_fill(1, -2);  do_step("R7");
    @(negedge clk); drive_fill(-1, 1);  do_step("R7");

    for (int n = 0; n < 15625; n++) begin
      @(negedge clk);
      x3 = from_code(n / 125, 3)[8:0];
      y3 = from_code(n % 125, 3)[8:0];
      x1 = from_code((n % 625) / 25, 2)[5:0];
      y1 = from_code(n % 25, 2)[5:0];
      x2 = x1;
      y2 = y1;
      x0 = rnd(4)[11:0]; y0 = rnd(4)[11:0];
      x4 = rnd(5)[14:0]; y4 = rnd(5)[14:0];
      do_step("R2");
    end

    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      x0 = rnd(4)[11:0]; y0 = rnd(4)[11:0];
      x1 = rnd(2)[5:0];  y1 = rnd(2)[5:0];
      x2 = rnd(2)[5:0];  y2 = rnd(2)[5:0];
      x3 = rnd(3)[8:0];  y3 = rnd(3)[8:0];
      x4 = rnd(5)[14:0]; y4 = rnd(5)[14:0];
      do_step("R2");
    end

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end
endmodule